// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs a single string primitive over memory as many times as a count register allows. It holds the architectural state of the operation: an element count, a source index, a destination index, an accumulator and a zero flag. A run is started with a primitive kind, a repeat kind, an element size, an address-size mode and a stepping direction. The five primitives are block move, fill from the accumulator, load into the accumulator, compare of two strings, and scan for the accumulator value. The sequencer steps through the elements, issues one single-port memory access at a time and waits for ready on each.

A run ends in one of two ways. The count can reach zero, or, for compare and scan under a conditional repeat kind, the zero flag can leave the state that the repeat kind requires. An interrupt request is sampled at the top of every iteration. When one is seen, the run is suspended with the registers left so that a plain restart finishes the work exactly as an uninterrupted run would. Software-side decode and address translation sit outside the block. The state registers are preloaded through a load strobe while the block is idle.

Top module: `strop_engine`

## Requirements
- R1: After reset the block is idle (busy, done, suspend and mem_req low) and count, source, destination, accumulator and zero flag are all zero.
- R2: A start whose count is zero in the selected address mode makes no memory access, leaves every register unchanged, and pulses done in the following cycle with cause 0.
- R3: Primitive codes are 0 move (read source, then write destination), 1 fill (write the accumulator to destination), 2 load (read source into the accumulator), 3 compare (read source, then read destination) and 4 scan (read destination). A request holds its address and write enable until ready is seen high.
- R4: Element-size code n (0..3) means 2^n bytes. Accesses drive the low 2^n byte enables, write data is zero above the element, and a load replaces only the low 2^n bytes of the accumulator.
- R5: With dir 0 each index the primitive uses grows by the element size after each element, and with dir 1 it shrinks by the element size. An index the primitive does not use is unchanged.
- R6: Address-mode code 0, 1 or 2 selects 16-, 32- or 64-bit count and indices. Only those low bits drive mem_addr and are updated, they wrap within that width, and the upper bits are preserved.
- R7: After each element the count drops by one. When it reaches zero the run ends with cause 0, whatever the flag holds.
- R8: Compare and scan set the zero flag to 1 when the two element values are equal and to 0 otherwise. Its value before the run has no effect.
- R9: Repeat kind 1 ends the run with cause 1 when the zero flag is 0 after the count check, and kind 2 does the same when it is 1. Kind 0, and any kind used with move, fill or load, ends only on the count.
- R10: When irq is high at the top of an iteration, no access is made and suspend pulses. The indices then point at the next unprocessed element and the count is as it was after the last completed element. A restart then reaches the same final state as an uninterrupted run.
- R11: A start with address-mode code 3, or with element-size code 3 outside 64-bit mode, is ignored: no access is made, there is no done, and no register changes.
- R12: done is high for exactly one cycle per finished run, and cause_o keeps its value until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Load the state registers from the ld_* inputs (idle only) |
| ld_cnt | input | 64 | Count value to load |
| ld_src | input | 64 | Source index to load |
| ld_dst | input | 64 | Destination index to load |
| ld_acc | input | 64 | Accumulator value to load |
| ld_zf | input | 1 | Zero flag value to load |
| start | input | 1 | Begin or resume a run (idle only) |
| prim | input | 3 | Primitive code |
| rkind | input | 2 | Repeat kind: 0 plain, 1 while equal, 2 while not equal |
| esize | input | 2 | Element size code |
| amode | input | 2 | Address-size mode code |
| dir | input | 1 | Stepping direction, 1 = decreasing |
| irq | input | 1 | Interrupt request, sampled between elements |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 64 | Byte address of the element |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data, element in the low bytes |
| mem_rdata | input | 64 | Read data, element in the low bytes |
| mem_rdy | input | 1 | Access completes in a cycle where this and mem_req are high |
| cnt_o | output | 64 | Count register |
| src_o | output | 64 | Source index register |
| dst_o | output | 64 | Destination index register |
| acc_o | output | 64 | Accumulator |
| zf_o | output | 1 | Zero flag |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| cause_o | output | 1 | End cause: 0 count reached zero, 1 flag condition |
| susp_o | output | 1 | One-cycle pulse when a run is suspended |

## Verification
The bench drives a count that is non-zero in its upper bits but zero in 16-bit mode. A design that tested the full register would then start accesses. In another run a scan matches on its last element, where a design that ranked the flag exit above the count exit would report cause 1. A 16-bit run that steps downward across address zero catches a design that clobbers or carries into the preserved upper index bits. Interrupts raised mid-run and before the first element check the resumable state, since a design that stepped an index before suspending would skip or repeat an element after restart. Random ready stalls catch a request that does not hold its address.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    PR_MOVE = 3'd0,
    PR_FILL = 3'd1,
    PR_LOAD = 3'd2,
    PR_CMP  = 3'd3,
    PR_SCAN = 3'd4
  } prim_e;

  typedef enum logic [1:0] {
    RK_PLAIN    = 2'd0,
    RK_WHILE_EQ = 2'd1,
    RK_WHILE_NE = 2'd2
  } rkind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TOP,
    S_ACC_A,
    S_ACC_B,
    S_STEP
  } seq_st_e;

  // window of live index/count bits for an address-size mode
  function automatic logic [63:0] mode_mask(input logic [1:0] am);
    case (am)
      2'd0:    mode_mask = 64'h0000_0000_0000_FFFF;
      2'd1:    mode_mask = 64'h0000_0000_FFFF_FFFF;
      default: mode_mask = '1;
    endcase
  endfunction

  function automatic logic cfg_ok(input logic [2:0] pr, input logic [1:0] rk,
                                  input logic [1:0] es, input logic [1:0] am);
    cfg_ok = (pr <= 3'd4) && (rk <= 2'd2) && (am <= 2'd2) &&
             !(es == 2'd3 && am != 2'd2);
  endfunction

endpackage

// File: rtl/strop_wrap.sv
module strop_wrap #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] win,
  input  logic [W-1:0] delta,
  input  logic         neg,
  output logic [W-1:0] nxt,
  output logic         zero
);
  logic [W-1:0] sum;

  always_comb begin
    sum  = neg ? (cur - delta) : (cur + delta);
    nxt  = (cur & ~win) | (sum & win);
    zero = ((nxt & win) == '0);
  end
endmodule

// File: rtl/strop_lane.sv
module strop_lane #(
  parameter int DW = 64
) (
  input  logic [1:0]      esz,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   dmask,
  output logic            eq
);
  localparam int NB = DW / 8;

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign be[j]            = (j < (1 << esz));
    assign dmask[8*j +: 8]  = {8{be[j]}};
  end

  assign eq = (((opa ^ opb) & dmask) == '0);
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [XLEN-1:0] ld_cnt,
  input  logic [XLEN-1:0] ld_src,
  input  logic [XLEN-1:0] ld_dst,
  input  logic [XLEN-1:0] ld_acc,
  input  logic            ld_zf,
  input  logic            start,
  input  logic [2:0]      prim,
  input  logic [1:0]      rkind,
  input  logic [1:0]      esize,
  input  logic [1:0]      amode,
  input  logic            dir,
  input  logic            irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_rdy,
  output logic [XLEN-1:0] cnt_o,
  output logic [XLEN-1:0] src_o,
  output logic [XLEN-1:0] dst_o,
  output logic [XLEN-1:0] acc_o,
  output logic            zf_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            cause_o,
  output logic            susp_o
);
  localparam int NB = XLEN / 8;

  seq_st_e         st_q;
  prim_e           prim_q;
  rkind_e          rk_q;
  logic [1:0]      esz_q, am_q;
  logic            dir_q;
  logic [XLEN-1:0] cnt_q, src_q, dst_q, acc_q, tmp_q;
  logic            zf_q, done_q, cause_q, susp_q;

  logic [XLEN-1:0] win, win_in, step, cnt_nx, src_nx, dst_nx;
  logic            cnt_zero, unused_z0, unused_z1;
  logic [XLEN-1:0] dmask, cmp_a;
  logic            lane_eq, uses_src, uses_dst, src_first, flag_stop, hs;

  assign win    = XLEN'(mode_mask(am_q));
  assign win_in = XLEN'(mode_mask(amode));
  assign step   = XLEN'(1) << esz_q;

  strop_wrap #(.W(XLEN)) u_cnt (.cur(cnt_q), .win(win), .delta(XLEN'(1)), .neg(1'b1),
                                .nxt(cnt_nx), .zero(cnt_zero));
  strop_wrap #(.W(XLEN)) u_src (.cur(src_q), .win(win), .delta(step), .neg(dir_q),
                                .nxt(src_nx), .zero(unused_z0));
  strop_wrap #(.W(XLEN)) u_dst (.cur(dst_q), .win(win), .delta(step), .neg(dir_q),
                                .nxt(dst_nx), .zero(unused_z1));

  assign cmp_a = (prim_q == PR_SCAN) ? acc_q : tmp_q;

  strop_lane #(.DW(XLEN)) u_lane (.esz(esz_q), .opa(cmp_a), .opb(mem_rdata),
                                  .be(mem_be), .dmask(dmask), .eq(lane_eq));

  always_comb begin
    uses_src  = (prim_q == PR_MOVE) || (prim_q == PR_LOAD) || (prim_q == PR_CMP);
    uses_dst  = (prim_q != PR_LOAD);
    src_first = uses_src;
    flag_stop = ((prim_q == PR_CMP) || (prim_q == PR_SCAN)) &&
                (((rk_q == RK_WHILE_EQ) && !zf_q) || ((rk_q == RK_WHILE_NE) && zf_q));
    mem_req   = (st_q == S_ACC_A) || (st_q == S_ACC_B);
    mem_we    = ((st_q == S_ACC_A) && (prim_q == PR_FILL)) ||
                ((st_q == S_ACC_B) && (prim_q == PR_MOVE));
    mem_addr  = (((st_q == S_ACC_A) && src_first) ? src_q : dst_q) & win;
    mem_wdata = ((prim_q == PR_FILL) ? acc_q : tmp_q) & dmask;
    hs        = mem_req && mem_rdy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      prim_q  <= PR_MOVE;
      rk_q    <= RK_PLAIN;
      esz_q   <= '0;
      am_q    <= '0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      acc_q   <= '0;
      tmp_q   <= '0;
      zf_q    <= 1'b0;
      done_q  <= 1'b0;
      cause_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      susp_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (ld) begin
            cnt_q <= ld_cnt;
            src_q <= ld_src;
            dst_q <= ld_dst;
            acc_q <= ld_acc;
            zf_q  <= ld_zf;
          end else if (start && cfg_ok(prim, rkind, esize, amode)) begin
            prim_q <= prim_e'(prim);
            rk_q   <= rkind_e'(rkind);
            esz_q  <= esize;
            am_q   <= amode;
            dir_q  <= dir;
            if ((cnt_q & win_in) == '0) begin
              done_q  <= 1'b1;
              cause_q <= 1'b0;
            end else begin
              st_q <= S_TOP;
            end
          end
        end
        S_TOP: begin
          if (irq) begin
            susp_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_ACC_A;
          end
        end
        S_ACC_A: begin
          if (hs) begin
            case (prim_q)
              PR_MOVE, PR_CMP: begin
                tmp_q <= mem_rdata;
                st_q  <= S_ACC_B;
              end
              PR_LOAD: begin
                acc_q <= (acc_q & ~dmask) | (mem_rdata & dmask);
                st_q  <= S_STEP;
              end
              PR_SCAN: begin
                zf_q <= lane_eq;
                st_q <= S_STEP;
              end
              default: st_q <= S_STEP;
            endcase
          end
        end
        S_ACC_B: begin
          if (hs) begin
            if (prim_q == PR_CMP) zf_q <= lane_eq;
            st_q <= S_STEP;
          end
        end
        S_STEP: begin
          cnt_q <= cnt_nx;
          if (uses_src) src_q <= src_nx;
          if (uses_dst) dst_q <= dst_nx;
          if (cnt_zero) begin
            done_q  <= 1'b1;
            cause_q <= 1'b0;
            st_q    <= S_IDLE;
          end else if (flag_stop) begin
            done_q  <= 1'b1;
            cause_q <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            st_q <= S_TOP;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign acc_o   = acc_q;
  assign zf_o    = zf_q;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign cause_o = cause_q;
  assign susp_o  = susp_q;

  logic unused_ok;
  assign unused_ok = unused_z0 ^ unused_z1 ^ (NB == 0);
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              ld,
  input logic [1:0]        amode,
  input logic              mem_req,
  input logic              mem_rdy,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN/8-1:0] mem_be,
  input logic              busy_o,
  input logic              done_o,
  input logic              susp_o,
  input logic [1:0]        am_q,
  input logic [1:0]        esz_q
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && am_q == 2'd0) |-> (mem_addr[XLEN-1:16] == '0));

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($countones(mem_be) == (1 << esz_q)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> !done_o);

  // R10
  susp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> (!busy_o && !mem_req));

  // R11
  bad_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !ld && !busy_o && amode == 2'd3) |=> (!busy_o && !done_o));
endmodule

bind strop_engine strop_engine_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ld(ld), .amode(amode),
  .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .busy_o(busy_o), .done_o(done_o), .susp_o(susp_o),
  .am_q(am_q), .esz_q(esz_q)
);

// File: tb/sim_strop_engine.sv
module sim_strop_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld = 1'b0, start = 1'b0, ld_zf = 1'b0, dir = 1'b0;
  logic [63:0] ld_cnt = '0, ld_src = '0, ld_dst = '0, ld_acc = '0;
  logic [2:0]  prim = '0;
  logic [1:0]  rkind = '0, esize = '0, amode = '0;
  logic        irq, irq_force = 1'b0, irq_hit = 1'b0;
  logic        mem_req, mem_we, mem_rdy = 1'b0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  mem_be;
  logic [63:0] cnt_o, src_o, dst_o, acc_o;
  logic        zf_o, busy_o, done_o, cause_o, susp_o;

  assign irq = irq_force | irq_hit;

  strop_engine u0 (
    .clk(clk), .rst(rst), .ld(ld), .ld_cnt(ld_cnt), .ld_src(ld_src), .ld_dst(ld_dst),
    .ld_acc(ld_acc), .ld_zf(ld_zf), .start(start), .prim(prim), .rkind(rkind),
    .esize(esize), .amode(amode), .dir(dir), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .cnt_o(cnt_o), .src_o(src_o),
    .dst_o(dst_o), .acc_o(acc_o), .zf_o(zf_o), .busy_o(busy_o), .done_o(done_o),
    .cause_o(cause_o), .susp_o(susp_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, hs_cnt = 0, irq_at_hs = -1;
  logic [7:0] bmem [0:255];
  logic [7:0] mmem [0:255];
  logic [7:0] lfsr = 8'h5A;

  logic [63:0] q_addr[$];
  logic        q_we[$];
  logic [63:0] q_wd[$];
  logic [7:0]  q_be[$];
  logic [63:0] m_cnt = '0, m_src = '0, m_dst = '0, m_acc = '0;
  logic        m_zf = 1'b0;

  always_comb begin
    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = bmem[8'(mem_addr[7:0] + 8'(k))];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // memory responder and per-clock access comparison
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", "run hung", 64'(cyc), 64'd150000);
      finish_up();
    end
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy = lfsr[0] | lfsr[2];
    if (done_o || susp_o) begin
      irq_hit = 1'b0;
      hs_cnt  = 0;
    end
    if (mem_req && mem_rdy) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R3", "unexpected access", mem_addr, 64'h0);
      end else begin
        logic [63:0] ea, ew; logic ewe; logic [7:0] eb;
        ea = q_addr.pop_front(); ewe = q_we.pop_front();
        ew = q_wd.pop_front(); eb = q_be.pop_front();
        chk(mem_addr == ea, "R6", "access address", mem_addr, ea);
        chk(mem_we == ewe, "R3", "access direction", 64'(mem_we), 64'(ewe));
        chk(mem_be == eb, "R4", "byte enables", 64'(mem_be), 64'(eb));
        if (ewe) chk(mem_wdata == ew, "R4", "write data", mem_wdata, ew);
      end
      if (mem_we)
        for (int k = 0; k < 8; k++)
          if (mem_be[k]) bmem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
      hs_cnt++;
      if (hs_cnt == irq_at_hs) irq_hit = 1'b1;
    end
  end

  function automatic logic [63:0] m_rd(input logic [63:0] a);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = mmem[8'(a[7:0] + 8'(k))];
    return v;
  endfunction

  task automatic push(input logic [63:0] a, input logic we, input logic [63:0] wd,
                      input logic [7:0] be);
    q_addr.push_back(a); q_we.push_back(we); q_wd.push_back(wd); q_be.push_back(be);
    if (we) for (int k = 0; k < 8; k++) if (be[k]) mmem[8'(a[7:0] + 8'(k))] = wd[8*k +: 8];
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] v);
    bmem[a] = v; mmem[a] = v;
  endtask

  task automatic load(input logic [63:0] c, s, d, a, input logic z);
    @(negedge clk);
    ld = 1'b1; ld_cnt = c; ld_src = s; ld_dst = d; ld_acc = a; ld_zf = z;
    @(negedge clk);
    ld = 1'b0;
    m_cnt = c; m_src = s; m_dst = d; m_acc = a; m_zf = z;
  endtask

  task automatic check_regs(input string req);
    chk(cnt_o == m_cnt, req, "count", cnt_o, m_cnt);
    chk(src_o == m_src, req, "source index", src_o, m_src);
    chk(dst_o == m_dst, req, "destination index", dst_o, m_dst);
    chk(acc_o == m_acc, req, "accumulator", acc_o, m_acc);
    chk(zf_o == m_zf, req, "zero flag", 64'(zf_o), 64'(m_zf));
  endtask

  // behavioural model of one run, then drive the DUT and compare
  task automatic run(input int pr, input int rk, input int es, input int am, input int dv,
                     input int irq_after, input string req);
    logic [63:0] m, sz, dm, v1, v2, dlt;
    logic [7:0] be;
    bit legal, e_done, e_susp, e_cause, seen_done, seen_susp, seen_cause;
    int it, nacc;
    legal = (am <= 2) && !(es == 3 && am != 2);
    m  = (am == 0) ? 64'hFFFF : (am == 1) ? 64'hFFFF_FFFF : '1;
    sz = 64'd1 << es;
    dm = (es == 3) ? '1 : ((64'd1 << (8 * sz)) - 64'd1);
    be = 8'((16'd1 << sz) - 16'd1);
    dlt = dv ? (64'd0 - sz) : sz;
    nacc = (pr == 0 || pr == 3) ? 2 : 1;
    e_done = 0; e_susp = 0; e_cause = 0;
    if (legal) begin
      if ((m_cnt & m) == 0) e_done = 1;
      it = 0;
      while (!e_done && !e_susp) begin
        if (it == irq_after) begin e_susp = 1; break; end
        case (pr)
          0: begin v1 = m_rd(m_src & m) & dm; push(m_src & m, 0, 0, be);
                   push(m_dst & m, 1, v1, be); end
          1: push(m_dst & m, 1, m_acc & dm, be);
          2: begin v1 = m_rd(m_src & m); push(m_src & m, 0, 0, be);
                   m_acc = (m_acc & ~dm) | (v1 & dm); end
          3: begin v1 = m_rd(m_src & m); push(m_src & m, 0, 0, be);
                   v2 = m_rd(m_dst & m); push(m_dst & m, 0, 0, be);
                   m_zf = ((v1 & dm) == (v2 & dm)); end
          default: begin v1 = m_rd(m_dst & m); push(m_dst & m, 0, 0, be);
                   m_zf = ((m_acc & dm) == (v1 & dm)); end
        endcase
        if (pr == 0 || pr == 2 || pr == 3) m_src = (m_src & ~m) | ((m_src + dlt) & m);
        if (pr != 2) m_dst = (m_dst & ~m) | ((m_dst + dlt) & m);
        m_cnt = (m_cnt & ~m) | ((m_cnt - 64'd1) & m);
        if ((m_cnt & m) == 0) e_done = 1;
        else if (pr >= 3 && ((rk == 1 && !m_zf) || (rk == 2 && m_zf))) begin
          e_done = 1; e_cause = 1;
        end
        it++;
      end
    end
    irq_at_hs = (irq_after > 0) ? irq_after * nacc : -1;
    @(negedge clk);
    prim = 3'(pr); rkind = 2'(rk); esize = 2'(es); amode = 2'(am); dir = dv[0];
    irq_force = (irq_after == 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen_done = 0; seen_susp = 0; seen_cause = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done_o) begin seen_done = 1; seen_cause = cause_o; end
      if (susp_o) seen_susp = 1;
      if (seen_done || seen_susp) break;
      if (!legal && i == 12) break;
      @(negedge clk);
    end
    irq_force = 1'b0;
    irq_at_hs = -1;
    chk(seen_done == e_done, req, "done seen", 64'(seen_done), 64'(e_done));
    chk(seen_susp == e_susp, req, "suspend seen", 64'(seen_susp), 64'(e_susp));
    if (e_done) chk(seen_cause == e_cause, req, "end cause", 64'(seen_cause), 64'(e_cause));
    chk(q_addr.size() == 0, req, "accesses left over", 64'(q_addr.size()), 64'd0);
    q_addr.delete(); q_we.delete(); q_wd.delete(); q_be.delete();
    check_regs(req);
    @(negedge clk);
    chk(!done_o, "R12", "done one cycle", 64'(done_o), 64'd0);
    if (e_done) chk(cause_o == e_cause, "R12", "cause held", 64'(cause_o), 64'(e_cause));
    chk(!busy_o, req, "idle after run", 64'(busy_o), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 13 + 5);
      mmem[i] = 8'(i * 13 + 5);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !susp_o && !mem_req, "R1", "idle flags", 64'(busy_o), 64'd0);
    check_regs("R1");

    // R2 count zero in 16-bit mode although upper bits set
    load(64'h0000_0000_0001_0000, 64'h10, 64'h20, 64'h77, 1'b1);
    run(0, 0, 0, 0, 0, -1, "R2");

    // R3 R5 move bytes upward, 32-bit mode
    load(64'd4, 64'h10, 64'hC0, 64'h0, 1'b0);
    run(0, 0, 0, 1, 0, -1, "R3");
    // R5 move halfwords downward
    load(64'd3, 64'h30, 64'hE0, 64'h0, 1'b0);
    run(0, 0, 1, 1, 1, -1, "R5");
    // R4 fill words
    load(64'd3, 64'h0, 64'h60, 64'hDEAD_BEEF_1234_5678, 1'b0);
    run(1, 0, 2, 2, 0, -1, "R4");
    // R4 load quadwords downward, last element stays
    load(64'd3, 64'h30, 64'h0, 64'h0, 1'b0);
    run(2, 0, 3, 2, 1, -1, "R4");
    // R4 byte load keeps upper accumulator bytes
    load(64'd2, 64'h50, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    run(2, 0, 0, 2, 0, -1, "R4");

    for (int i = 0; i < 6; i++) begin
      poke(8'(8'h40 + i), 8'(i + 1));
      poke(8'(8'h80 + i), (i == 2) ? 8'h09 : 8'(i + 1));
    end
    // R9 while-equal compare stops on mismatch
    load(64'd6, 64'h40, 64'h80, 64'h0, 1'b1);
    run(3, 1, 0, 1, 0, -1, "R9");
    // R8 equal strings run to count end, zf set
    load(64'd3, 64'h43, 64'h83, 64'h0, 1'b0);
    run(3, 1, 0, 1, 0, -1, "R8");
    // R8 plain compare ignores mismatches
    load(64'd6, 64'h40, 64'h80, 64'h0, 1'b0);
    run(3, 0, 0, 1, 0, -1, "R8");

    for (int i = 0; i < 8; i++) poke(8'(8'hA0 + i), (i == 3) ? 8'h55 : 8'(8'h10 + i));
    // R9 while-not-equal scan stops on the match
    load(64'd8, 64'h0, 64'hA0, 64'h1122_3344_5566_7755, 1'b1);
    run(4, 2, 0, 1, 0, -1, "R9");
    // R7 match on final element: count exit wins
    load(64'd4, 64'h0, 64'hA0, 64'h1122_3344_5566_7755, 1'b1);
    run(4, 2, 0, 1, 0, -1, "R7");
    // R9 flag kind on a move has no effect
    load(64'd3, 64'h10, 64'hC8, 64'h0, 1'b0);
    run(0, 1, 0, 1, 0, -1, "R9");

    // R6 16-bit wrap downward, upper bits preserved
    load(64'hFFFF_0000_0000_0003, 64'hABCD_0000_0000_0002, 64'h1234_0000_0000_00D0,
         64'h0, 1'b0);
    run(0, 0, 1, 0, 1, -1, "R6");

    // R10 suspend after two elements, then resume
    load(64'd5, 64'h10, 64'hC0, 64'h0, 1'b0);
    run(0, 0, 2, 1, 0, 2, "R10");
    run(0, 0, 2, 1, 0, -1, "R10");
    // R10 interrupt pending before the first element
    load(64'd3, 64'h0, 64'hA0, 64'h55, 1'b0);
    run(4, 1, 0, 1, 0, 0, "R10");

    // R11 illegal configurations ignored
    load(64'd3, 64'h10, 64'h20, 64'h99, 1'b1);
    run(0, 0, 3, 1, 0, -1, "R11");
    run(1, 0, 0, 3, 0, -1, "R11");

    finish_up();
  end
endmodule